// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one WIDTH-bit integer by another over several clock cycles and returns a quotient and a remainder. It uses a restoring scheme that needs only one subtractor. A single register pair holds the partial remainder and the quotient. The quotient half starts out holding the dividend magnitude, and the remainder half starts at zero. On each iteration the pair shifts one place to the left and the divisor is trial-subtracted from the upper half. If the difference is not negative, it replaces the partial remainder and a one enters the quotient from the right. Otherwise the partial remainder is kept and a zero enters.

A caller pulses `start_i` with the operands and the mode bit while the block is idle. In signed mode both operands are reduced to magnitudes before the loop. After the loop, the quotient is negated when the operand signs differ, and the remainder is negated when the dividend is negative. Integer division therefore truncates toward zero, and dividend = quotient × divisor + remainder always holds. A zero divisor raises a flag and produces a defined result; no trap or exception is taken.

Top module: `seq_divider`

## Requirements
- R1: A start pulse seen while `busy_o` is low is accepted on that clock edge, and `busy_o` is high in the cycle that follows.
- R2: In unsigned mode (`signed_i` = 0) the results are floor(dividend / divisor) and dividend mod divisor; for example, 14 / 3 gives quotient 4 and remainder 2.
- R3: In signed mode (`signed_i` = 1, two's complement operands) the quotient is truncated toward zero, and it is negative exactly when the operand signs differ: −17 / 3 gives −5 remainder −2, and 17 / −3 gives −5 remainder +2.
- R4: A non-zero signed remainder has the same sign as the dividend. For every non-zero divisor, quotient × divisor + remainder equals the dividend modulo 2^WIDTH.
- R5: `done_o` is a one-cycle pulse that rises exactly WIDTH+1 clock edges after the accepting edge. In that cycle `busy_o` is low. `busy_o` is high through all the cycles in between.
- R6: A start pulse that arrives while `busy_o` is high is ignored: the running division completes with its own operands, and no extra `done_o` pulse follows.
- R7: A zero divisor sets `div_by_zero_o` together with `done_o`. The quotient is then all ones and the remainder equals the dividend, in both modes, with the same latency. A non-zero divisor clears the flag.
- R8: In signed mode, the most negative value divided by −1 yields the most negative value as the quotient (the result wraps) and zero as the remainder.
- R9: In unsigned mode, operands near 2^WIDTH give exact results (for example, 255 / 128 → 1 r 127, 254 / 255 → 0 r 254, 255 / 1 → 255 r 0 at WIDTH = 8), because the trial difference is one bit wider than the operands.
- R10: Reset clears the quotient, remainder, flag, `busy_o` and `done_o` to zero. The result outputs keep their value in every cycle except the one in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a division when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | WIDTH | Dividend, sampled on the accepting edge |
| divisor_i | input | WIDTH | Divisor, sampled on the accepting edge |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse: new results are valid |
| quotient_o | output | WIDTH | Quotient of the last finished division |
| remainder_o | output | WIDTH | Remainder of the last finished division |
| div_by_zero_o | output | 1 | The last finished division had a zero divisor |

## Verification
The bench builds the divider with WIDTH = 8. At this width every boundary operand can be written out and checked: the most negative value −128, all-ones 255, and divisors just below and above the dividend. At the same time the WIDTH+1-cycle latency is short enough for a long deterministic sweep over both modes. Expected results come from the simulator's own integer division, which truncates toward zero, and each result is cross-checked with the dividend identity and the remainder-sign rule.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOOP = 2'd1,
        PH_FIX  = 2'd2
    } phase_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] value_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        neg_o = signed_i & value_i[W-1];
        mag_o = neg_o ? ((~value_i) + ONE) : value_i;
    end

endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         fits;

    always_comb begin
        // pair shifted one place left; top bit of remainder kept as carry
        shifted = {rem_i, quo_i[W-1]};
        diff    = {1'b0, shifted} - {2'b00, dsr_i};
        // a non-negative difference is always below the divisor, so bit W is clear
        fits    = ~(diff[W+1] | diff[W]);
        rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag_i,
    input  logic [W-1:0] rem_mag_i,
    input  logic         quo_neg_i,
    input  logic         rem_neg_i,
    input  logic         zero_div_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (zero_div_i) begin
            quo_o = '1;
        end else if (quo_neg_i) begin
            quo_o = (~quo_mag_i) + ONE;
        end else begin
            quo_o = quo_mag_i;
        end
        // with a zero divisor the magnitude is the dividend's, so this restores it
        rem_o = rem_neg_i ? ((~rem_mag_i) + ONE) : rem_mag_i;
    end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             div_by_zero_o
);
    localparam int CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] dsr;
        logic             q_neg;
        logic             r_neg;
        logic             zdiv;
        logic [WIDTH-1:0] q_out;
        logic [WIDTH-1:0] r_out;
        logic             zdiv_out;
        logic             done;
    } state_t;

    state_t st_q, st_d;

    logic [WIDTH-1:0] dd_mag, dv_mag;
    logic             dd_neg, dv_neg;
    logic [WIDTH-1:0] step_rem, step_quo;
    logic [WIDTH-1:0] fix_quo, fix_rem;

    div_operand_prep #(.W(WIDTH)) u_prep_dd (
        .value_i  (dividend_i),
        .signed_i (signed_i),
        .mag_o    (dd_mag),
        .neg_o    (dd_neg)
    );

    div_operand_prep #(.W(WIDTH)) u_prep_dv (
        .value_i  (divisor_i),
        .signed_i (signed_i),
        .mag_o    (dv_mag),
        .neg_o    (dv_neg)
    );

    div_restore_step #(.W(WIDTH)) u_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dsr_i (st_q.dsr),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    div_result_fix #(.W(WIDTH)) u_fix (
        .quo_mag_i  (st_q.quo),
        .rem_mag_i  (st_q.rem),
        .quo_neg_i  (st_q.q_neg),
        .rem_neg_i  (st_q.r_neg),
        .zero_div_i (st_q.zdiv),
        .quo_o      (fix_quo),
        .rem_o      (fix_rem)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_LOOP;
                    st_d.cnt   = '0;
                    st_d.rem   = '0;
                    st_d.quo   = dd_mag;
                    st_d.dsr   = dv_mag;
                    st_d.q_neg = dd_neg ^ dv_neg;
                    st_d.r_neg = dd_neg;
                    st_d.zdiv  = (divisor_i == '0);
                end
            end
            PH_LOOP: begin
                st_d.rem = step_rem;
                st_d.quo = step_quo;
                st_d.cnt = st_q.cnt + CNT_ONE;
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_FIX;
                end
            end
            PH_FIX: begin
                st_d.q_out    = fix_quo;
                st_d.r_out    = fix_rem;
                st_d.zdiv_out = st_q.zdiv;
                st_d.done     = 1'b1;
                st_d.phase    = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o        = (st_q.phase != PH_IDLE);
    assign done_o        = st_q.done;
    assign quotient_o    = st_q.q_out;
    assign remainder_o   = st_q.r_out;
    assign div_by_zero_o = st_q.zdiv_out;

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         div_by_zero_o,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o
);

    assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_zero_div_quot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_by_zero_o) |-> (quotient_o == {W{1'b1}}));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_by_zero_o)));

endmodule

bind seq_divider div_checker #(.W(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .div_by_zero_o (div_by_zero_o),
    .quotient_o    (quotient_o),
    .remainder_o   (remainder_o)
);

// File: tb/sim_seq_divider.sv
`timescale 1ns/1ps
module sim_seq_divider;
    localparam int W = 8;
    localparam int NVEC = 14;
    // {signed, dividend, divisor}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'd14,  8'd3},   // R2
        {1'b1, 8'hEF,  8'd3},   // R3 -17/3
        {1'b1, 8'h11,  8'hFD},  // R3 17/-3
        {1'b1, 8'hEF,  8'hFD},  // R3/R4 -17/-3
        {1'b1, 8'h11,  8'd3},   // R3 17/3
        {1'b0, 8'd255, 8'd128}, // R9
        {1'b0, 8'd255, 8'd255}, // R9
        {1'b0, 8'd254, 8'd255}, // R9
        {1'b0, 8'd255, 8'd1},   // R9
        {1'b1, 8'h80,  8'hFF},  // R8
        {1'b1, 8'h80,  8'd1},   // R8 neighbour
        {1'b0, 8'd7,   8'd0},   // R7
        {1'b1, 8'hFB,  8'd0},   // R7 signed
        {1'b0, 8'd0,   8'd5}    // R2 zero dividend
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sgn = 1'b0;
    logic [W-1:0] dd = '0;
    logic [W-1:0] dv = '0;
    logic         busy, done, dz;
    logic [W-1:0] quo, rem;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    seq_divider #(.WIDTH(W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .signed_i      (sgn),
        .dividend_i    (dd),
        .divisor_i     (dv),
        .busy_o        (busy),
        .done_o        (done),
        .quotient_o    (quo),
        .remainder_o   (rem),
        .div_by_zero_o (dz)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] q, output logic [W-1:0] r, output logic z);
        int qi, ri;
        if (b == '0) begin
            q = '1; r = a; z = 1'b1;
        end else begin
            z = 1'b0;
            if (s) begin
                qi = $signed(a) / $signed(b);
                ri = $signed(a) % $signed(b);
            end else begin
                qi = int'(a) / int'(b);
                ri = int'(a) % int'(b);
            end
            q = qi[W-1:0]; r = ri[W-1:0];
        end
    endtask

    task automatic run_op(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                          output int cyc);
        @(negedge clk);
        start = 1'b1; sgn = s; dd = a; dv = b;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic do_check(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                            input string tag);
        logic [W-1:0] eq, er, prod;
        logic ez;
        int cyc;
        model(s, a, b, eq, er, ez);
        run_op(s, a, b, cyc);
        check(cyc == W + 1, "R5 latency", cyc, W + 1);
        check(quo == eq, {tag, " quotient"}, int'(quo), int'(eq));
        check(rem == er, {tag, " remainder"}, int'(rem), int'(er));
        check(dz == ez, "R7 flag", int'(dz), int'(ez));
        if (!ez) begin
            prod = quo * b + rem;
            check(prod == a, "R4 identity", int'(prod), int'(a));
            if (s && rem != '0)
                check(rem[W-1] == a[W-1], "R4 remainder sign", int'(rem[W-1]), int'(a[W-1]));
        end
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [W-1:0] held_q;
        logic saw_done;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 1'b0, "R10 reset busy", int'(busy), 0);
        check(done == 1'b0, "R10 reset done", int'(done), 0);
        check(quo == '0, "R10 reset quotient", int'(quo), 0);
        check(rem == '0, "R10 reset remainder", int'(rem), 0);
        check(dz == 1'b0, "R10 reset flag", int'(dz), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            do_check(VEC[i][16], VEC[i][15:8], VEC[i][7:0], "R2/R3/R8/R9 table");
        end

        // R1 and R6: start accepted, then a second start while busy is ignored
        @(negedge clk);
        start = 1'b1; sgn = 1'b0; dd = 8'd100; dv = 8'd7;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
        repeat (2) @(negedge clk);
        start = 1'b1; dd = 8'd50; dv = 8'd5;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5 busy mid-run", int'(busy), 1);
        cyc = 3;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == W + 1, "R6 latency unchanged", cyc, W + 1);
        check(quo == 8'd14, "R6 quotient of first op", int'(quo), 14);
        check(rem == 8'd2, "R6 remainder of first op", int'(rem), 2);
        held_q = quo;
        saw_done = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) saw_done = 1'b1;
        end
        check(!saw_done, "R6 no extra done", int'(saw_done), 0);
        check(busy == 1'b0, "R6 idle afterwards", int'(busy), 0);
        check(quo == held_q, "R10 result held", int'(quo), int'(held_q));

        // R7 then R7 flag clears on a later non-zero divisor
        do_check(1'b1, 8'h80, 8'd0, "R7 most negative by zero");
        do_check(1'b0, 8'd9, 8'd2, "R7 flag clear");

        // sweep over both modes
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a, b;
            a = 8'((i * 37 + 11) % 256);
            b = 8'((i * 53 + 3) % 256);
            if (i % 5 == 0) b = 8'(b >> 5);
            do_check(i[0], a, b, "R2/R3 sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule